// File: doc/BRIEF.md
# Vectored Interrupt Controller Register File

This block gathers 32 interrupt request lines into two processor interrupt outputs: a fast one and a normal one. Software reaches it over a simple synchronous register port that has an address, write data, a write strobe, a read strobe and a privilege flag. Read data is combinational on the cycle the read strobe is high. The block can also raise any line from software, and that request is ORed with the hardware line. Each source has an enable bit, and a class bit steers it to one of the two outputs. Software can read the raw, fast and normal status words.

For the normal class, sixteen vectored slots map a source number to a service-routine address. Slot 0 has the highest priority. Reading the vector register returns the address of the first enabled slot whose source has a pending normal interrupt, or a default address when no slot matches. The first read freezes the vector value. A write to the vector register acknowledges the interrupt and releases the value. A protection bit can restrict every register access to privileged callers.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all registers, status words, the vector value, `irq_o` and `fiq_o` are 0.
- R2: Offset 0x008 reads `src_req` ORed with the software request word, whatever the enable and class bits are.
- R3: Offset 0x00C is the class word and is read/write. A 1 selects fast and a 0 selects normal. Offset 0x004 reads raw AND enable AND class. Offset 0x000 reads raw AND enable AND NOT class.
- R4: Writing to 0x010 sets the enable bits where the data has 1s and leaves the other bits alone. Reading 0x010 returns the enable word. Writing 1s to 0x014 clears the matching enable bits. Reading 0x014 returns 0.
- R5: Writing to 0x018 sets bits of the software request word where the data has 1s. Reading 0x018 returns that word. Writing 1s to 0x01C clears the matching bits. Reading 0x01C returns 0.
- R6: `irq_o` is the OR of the normal status word one clock later. `fiq_o` is the OR of the fast status word one clock later.
- R7: Slot n has a 32-bit address register at 0x100+4n and a control register at 0x200+4n. In the control register, bit 5 is the slot enable and bits 4:0 are the source number. The vector register at 0x030 returns the address of the lowest-numbered enabled slot whose source is set in the normal status word.
- R8: When no enabled slot matches, including the case where the slot's source is disabled or classed as fast, 0x030 returns the default address that is read/write at 0x034.
- R9: When not frozen, the vector value is registered from the current selection every cycle. A permitted read of 0x030 freezes it. A permitted write to 0x030 unfreezes it, and after that clock edge 0x030 shows the selection made in the write cycle.
- R10: Bit 0 of 0x020 is the protection bit. While it is 1, an access with `bus_priv` low reads 0 and its write is ignored, and this includes writes to 0x020 itself.
- R11: Unmapped offsets read 0, and so do slot offsets at or beyond slot 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_req | input | 32 | Hardware request lines |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_priv | input | 1 | Caller is privileged |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_re` |
| irq_o | output | 1 | Normal interrupt, registered |
| fiq_o | output | 1 | Fast interrupt, registered |

## Verification
The acknowledge write to the vector register can land in the same cycle that a new, higher-priority hardware request rises. The bench freezes the vector on a lower-priority slot. It then writes the acknowledge and, in that same cycle, raises a request on slot 0's source. On the next read it expects slot 0's address, not the value that was frozen and not the value that was pending before. It also requests several slots in the same cycle to check that the lowest slot number wins.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int AW    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic            bus_priv,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);

  localparam int SRCW = $clog2(NSRC);
  localparam int SLW  = $clog2(NSLOT);
  localparam int CTLW = SRCW + 1;

  localparam logic [AW-1:0] OFS_NSTAT  = AW'('h000);
  localparam logic [AW-1:0] OFS_FSTAT  = AW'('h004);
  localparam logic [AW-1:0] OFS_RAW    = AW'('h008);
  localparam logic [AW-1:0] OFS_CLASS  = AW'('h00C);
  localparam logic [AW-1:0] OFS_EN     = AW'('h010);
  localparam logic [AW-1:0] OFS_ENCLR  = AW'('h014);
  localparam logic [AW-1:0] OFS_SOFT   = AW'('h018);
  localparam logic [AW-1:0] OFS_SFCLR  = AW'('h01C);
  localparam logic [AW-1:0] OFS_PROT   = AW'('h020);
  localparam logic [AW-1:0] OFS_VEC    = AW'('h030);
  localparam logic [AW-1:0] OFS_DEF    = AW'('h034);

  logic [NSRC-1:0] class_q, en_q, soft_q;
  logic            prot_q;
  logic [DW-1:0]   defvec_q, vec_q, pick;
  logic            vec_lock_q;
  logic            irq_q, fiq_q;
  logic [DW-1:0]   slot_addr_q [NSLOT];
  logic [CTLW-1:0] slot_ctl_q  [NSLOT];

  wire access_ok = !prot_q || bus_priv;
  wire wr = bus_we && access_ok;
  wire rd = bus_re && access_ok;

  wire [NSRC-1:0] raw    = src_req | soft_q;
  wire [NSRC-1:0] n_stat = raw & en_q & ~class_q;
  wire [NSRC-1:0] f_stat = raw & en_q & class_q;
  wire [NSRC-1:0] wsrc   = bus_wdata[NSRC-1:0];

  wire slot_win = (bus_addr[1:0] == 2'b00) && (bus_addr[7:2] < 6'(NSLOT));
  wire in_vaddr = slot_win && (bus_addr[AW-1:8] == (AW-8)'(1));
  wire in_vctl  = slot_win && (bus_addr[AW-1:8] == (AW-8)'(2));
  wire [SLW-1:0] sidx = bus_addr[2 +: SLW];

  wire ack    = wr && (bus_addr == OFS_VEC);
  wire vec_rd = rd && (bus_addr == OFS_VEC);

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  always_comb begin
    pick = defvec_q;
    for (int n = NSLOT - 1; n >= 0; n--)
      if (slot_ctl_q[n][SRCW] && n_stat[slot_ctl_q[n][SRCW-1:0]])
        pick = slot_addr_q[n];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == OFS_NSTAT)      bus_rdata = DW'(n_stat);
      else if (bus_addr == OFS_FSTAT) bus_rdata = DW'(f_stat);
      else if (bus_addr == OFS_RAW)   bus_rdata = DW'(raw);
      else if (bus_addr == OFS_CLASS) bus_rdata = DW'(class_q);
      else if (bus_addr == OFS_EN)    bus_rdata = DW'(en_q);
      else if (bus_addr == OFS_SOFT)  bus_rdata = DW'(soft_q);
      else if (bus_addr == OFS_PROT)  bus_rdata = DW'(prot_q);
      else if (bus_addr == OFS_VEC)   bus_rdata = vec_q;
      else if (bus_addr == OFS_DEF)   bus_rdata = defvec_q;
      else if (in_vaddr)              bus_rdata = slot_addr_q[sidx];
      else if (in_vctl)               bus_rdata = DW'(slot_ctl_q[sidx]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_q    <= '0;
      en_q       <= '0;
      soft_q     <= '0;
      prot_q     <= 1'b0;
      defvec_q   <= '0;
      vec_q      <= '0;
      vec_lock_q <= 1'b0;
      irq_q      <= 1'b0;
      fiq_q      <= 1'b0;
      for (int n = 0; n < NSLOT; n++) begin
        slot_addr_q[n] <= '0;
        slot_ctl_q[n]  <= '0;
      end
    end else begin
      irq_q <= |n_stat;
      fiq_q <= |f_stat;
      if (wr) begin
        if (bus_addr == OFS_CLASS) class_q  <= wsrc;
        if (bus_addr == OFS_EN)    en_q     <= en_q | wsrc;
        if (bus_addr == OFS_ENCLR) en_q     <= en_q & ~wsrc;
        if (bus_addr == OFS_SOFT)  soft_q   <= soft_q | wsrc;
        if (bus_addr == OFS_SFCLR) soft_q   <= soft_q & ~wsrc;
        if (bus_addr == OFS_PROT)  prot_q   <= bus_wdata[0];
        if (bus_addr == OFS_DEF)   defvec_q <= bus_wdata;
        if (in_vaddr) slot_addr_q[sidx] <= bus_wdata;
        if (in_vctl)  slot_ctl_q[sidx]  <= bus_wdata[CTLW-1:0];
      end
      if (ack) begin
        vec_lock_q <= 1'b0;
        vec_q      <= pick;
      end else if (vec_rd) begin
        vec_lock_q <= 1'b1;
      end else if (!vec_lock_q) begin
        vec_q <= pick;
      end
    end
  end

  AST_ENCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == OFS_ENCLR |=> (en_q & $past(wsrc)) == '0);  // R4
  AST_SOFTCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == OFS_SFCLR |=> (soft_q & $past(wsrc)) == '0);  // R5
  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == '0 |=> !irq_o && !fiq_o);  // R6
  AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    vec_lock_q && !ack |=> $stable(vec_q));  // R9
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !vec_lock_q);  // R9
  AST_PROT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !access_ok |=> $stable(en_q) && $stable(class_q) && $stable(soft_q) && $stable(prot_q));  // R10
  AST_PROT_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && prot_q && !bus_priv |-> bus_rdata == '0);  // R10

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0, bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  int nchk = 0, nfail = 0;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {src_req, enable, class, software}
  localparam logic [31:0] TV [4][4] = '{
    '{32'h0000_00F0, 32'h0000_00FF, 32'h0000_0030, 32'h0000_0000},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001},
    '{32'hFFFF_0000, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'h1234_5678, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'h0000_0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_re = 1'b0;
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] raw, ns, fs;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq_o", {31'b0, irq_o}, 0);
    chk("R1 fiq_o", {31'b0, fiq_o}, 0);
    rchk(12'h000, 0, "R1 normal status");
    rchk(12'h004, 0, "R1 fast status");
    rchk(12'h008, 0, "R1 raw");
    rchk(12'h00C, 0, "R1 class");
    rchk(12'h010, 0, "R1 enable");
    rchk(12'h018, 0, "R1 soft");
    rchk(12'h020, 0, "R1 prot");
    rchk(12'h034, 0, "R1 default");
    rchk(12'h100, 0, "R1 slot addr");
    rchk(12'h200, 0, "R1 slot ctl");
    rchk(12'h030, 0, "R1 vector");
    wreg(12'h030, 0);

    // Table walk: R2 R3 R6
    foreach (TV[i]) begin
      src_req = TV[i][0];
      wreg(12'h014, 32'hFFFF_FFFF);
      wreg(12'h010, TV[i][1]);
      wreg(12'h00C, TV[i][2]);
      wreg(12'h01C, 32'hFFFF_FFFF);
      wreg(12'h018, TV[i][3]);
      raw = TV[i][0] | TV[i][3];
      ns  = raw & TV[i][1] & ~TV[i][2];
      fs  = raw & TV[i][1] & TV[i][2];
      rchk(12'h008, raw, "R2 raw");
      rchk(12'h000, ns, "R3 normal status");
      rchk(12'h004, fs, "R3 fast status");
      rchk(12'h00C, TV[i][2], "R3 class readback");
      idle(1);
      chk("R6 irq_o", {31'b0, irq_o}, {31'b0, |ns});
      chk("R6 fiq_o", {31'b0, fiq_o}, {31'b0, |fs});
    end

    // R4 enable set / clear
    src_req = '0;
    wreg(12'h014, 32'hFFFF_FFFF);
    wreg(12'h010, 32'h0000_000F);
    wreg(12'h010, 32'h0000_00F0);
    rchk(12'h010, 32'h0000_00FF, "R4 set keeps other bits");
    wreg(12'h014, 32'h0000_000F);
    rchk(12'h010, 32'h0000_00F0, "R4 clear");
    rchk(12'h014, 0, "R4 clear alias reads 0");

    // R5 software set / clear
    wreg(12'h01C, 32'hFFFF_FFFF);
    wreg(12'h018, 32'h0000_0300);
    wreg(12'h018, 32'h0001_0000);
    rchk(12'h018, 32'h0001_0300, "R5 set keeps other bits");
    wreg(12'h01C, 32'h0000_0100);
    rchk(12'h018, 32'h0001_0200, "R5 clear");
    rchk(12'h01C, 0, "R5 clear alias reads 0");
    wreg(12'h01C, 32'hFFFF_FFFF);

    // Vector setup
    wreg(12'h00C, 0);
    wreg(12'h010, 32'hFFFF_FFFF);
    wreg(12'h034, 32'h0000_D000);
    wreg(12'h100, 32'h0000_A000); wreg(12'h200, 32'h25);
    wreg(12'h10C, 32'h0000_A300); wreg(12'h20C, 32'h29);
    wreg(12'h13C, 32'h0000_AF00); wreg(12'h23C, 32'h3F);
    rchk(12'h20C, 32'h29, "R7 slot ctl readback");
    rchk(12'h13C, 32'h0000_AF00, "R7 last slot addr");
    rchk(12'h034, 32'h0000_D000, "R8 default readback");

    // R7 priority
    src_req = (32'h1 << 9) | (32'h1 << 31);
    idle(1);
    rchk(12'h030, 32'h0000_A300, "R7 lower slot wins");
    wreg(12'h030, 0);

    // R9 freeze, acknowledge, and acknowledge in the cycle a new request rises
    src_req = 32'h1 << 31;
    idle(1);
    rchk(12'h030, 32'h0000_AF00, "R9 first read");
    src_req = 32'h1 << 9;
    idle(2);
    rchk(12'h030, 32'h0000_AF00, "R9 frozen after read");
    wreg(12'h030, 0);
    rchk(12'h030, 32'h0000_A300, "R9 after acknowledge");
    @(negedge clk);
    bus_addr = 12'h030; bus_wdata = 0; bus_we = 1'b1;
    src_req = (32'h1 << 9) | (32'h1 << 5);
    @(posedge clk); #1;
    bus_we = 1'b0;
    rchk(12'h030, 32'h0000_A000, "R9 acknowledge with new request same cycle");
    wreg(12'h030, 0);

    // R8 default fallbacks
    src_req = 32'h1 << 12;
    idle(1);
    rchk(12'h030, 32'h0000_D000, "R8 no slot for source");
    wreg(12'h030, 0);
    wreg(12'h200, 32'h05);
    src_req = 32'h1 << 5;
    idle(1);
    rchk(12'h030, 32'h0000_D000, "R8 disabled slot");
    wreg(12'h030, 0);
    wreg(12'h00C, 32'h1 << 9);
    src_req = 32'h1 << 9;
    idle(1);
    rchk(12'h030, 32'h0000_D000, "R8 fast-class source");
    wreg(12'h030, 0);

    // R10 protection
    bus_priv = 1'b0;
    wreg(12'h020, 1);
    wreg(12'h014, 32'hFFFF_FFFF);
    rchk(12'h010, 0, "R10 unprivileged read is 0");
    bus_priv = 1'b1;
    rchk(12'h010, 32'hFFFF_FFFF, "R10 unprivileged write ignored");
    bus_priv = 1'b0;
    wreg(12'h020, 0);
    bus_priv = 1'b1;
    rchk(12'h020, 1, "R10 protection bit self-protected");
    wreg(12'h020, 0);
    bus_priv = 1'b0;
    rchk(12'h020, 0, "R10 privileged clear");

    // R11 unmapped
    rchk(12'h03C, 0, "R11 unmapped");
    rchk(12'h140, 0, "R11 slot beyond range");
    rchk(12'h300, 0, "R11 high region");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule